// File: doc/BRIEF.md
# Incremental Encoder Position Counter

This block turns two filtered, clock-synchronous encoder signals into a running position count and a direction flag. In the default quadrature mode it decodes all four edges of the two-phase pattern. A reverse-select input swaps the two channels, so the same wiring can count the other way. In the alternative frequency/direction mode, channel A carries a step clock and channel B carries the sign. Every edge of A, rising or falling, moves the count by one.

The block keeps the raw pin state of the previous cycle and compares it with the present pins. Each legal step produces a one-cycle strobe together with the updated count. A two-bit jump in quadrature mode is treated as invalid and is dropped. The count is a two's-complement register that wraps at both ends.

Top module: `enc_pos_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, posCount is 0, countStrobe is 0 and dirUp is 1. The registered reverse and mode settings clear to 0.
- R2: In quadrature mode the decoder inputs are (a,b). The legal cycle is 00 -> 10 -> 11 -> 01 -> 00, with a written first. Each move one place forward in that cycle adds 1 to posCount. This is x4 decoding: every edge of either channel counts.
- R3: In quadrature mode, each move one place backward in that cycle subtracts 1 from posCount.
- R4: dirUp becomes 1 with every up step and 0 with every down step. It holds its value when no step occurs.
- R5: If neither pin changes, posCount does not change and no strobe is issued. In quadrature mode, if both pins change in the same cycle, the same applies.
- R6: With the registered reverse setting at 0, pin A drives decoder input a and pin B drives b. With the setting at 1, pin B drives a and pin A drives b.
- R7: In frequency/direction mode, every rising or falling edge of pin A steps the count. If pin B is 0 in that cycle the count goes up; if pin B is 1 it goes down. Edges of pin B alone do not count, and the reverse setting has no effect.
- R8: A pin change sampled at clock edge k appears at edge k. At that edge posCount is updated and countStrobe goes high. countStrobe stays high for exactly that one cycle per step.
- R9: posCount is CNT_W bits wide and wraps modulo 2^CNT_W. A down step from 0 gives all ones, and an up step from all ones gives 0.
- R10: revSel and fdMode are registered. A new value applies from the clock edge after the one that samples it. Changing either of them while the pins are steady never produces a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chanA | input | 1 | Filtered encoder channel A (step clock in frequency/direction mode) |
| chanB | input | 1 | Filtered encoder channel B (direction level in frequency/direction mode) |
| revSel | input | 1 | Swap channels A and B for quadrature decoding |
| fdMode | input | 1 | 1 selects frequency/direction mode, 0 selects quadrature |
| posCount | output | CNT_W | Two's-complement position count |
| countStrobe | output | 1 | One-cycle pulse for every counted step |
| dirUp | output | 1 | 1 after an up step, 0 after a down step |

## Verification
A configuration change and a pin transition can fall on the same clock edge. In that case the registered setting still holds its old value for that one decode. The bench provokes this by changing revSel, or fdMode, on the same falling edge as a pin move. It expects the step to be counted under the old setting, and the next step under the new one. The bench also sweeps every pair of pin states under every combination of mode and reverse. It computes each expected delta from the position in the legal cycle.

// File: rtl/enc_pos_pkg.sv
package enc_pos_pkg;

  // Strobes from the decode control to the count datapath
  typedef struct packed {
    logic stepUp;
    logic stepDn;
  } step_t;

  // Position of a decoder state (a,b) in the forward cycle 00,10,11,01
  function automatic logic [1:0] phaseIdx(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

endpackage

// File: rtl/enc_pos_ctrl.sv
module enc_pos_ctrl
  import enc_pos_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  chanA,
  input  logic  chanB,
  input  logic  revSel,
  input  logic  fdMode,
  output step_t steps
);

  logic       revQ;
  logic       modeQ;
  logic [1:0] pinPrev;   // {A,B} raw pins from the previous cycle

  // The previous pins are tracked even during reset, so release never counts
  always_ff @(posedge clk) begin
    if (rst) begin
      revQ    <= 1'b0;
      modeQ   <= 1'b0;
      pinPrev <= {chanA, chanB};
    end else begin
      revQ    <= revSel;
      modeQ   <= fdMode;
      pinPrev <= {chanA, chanB};
    end
  end

  // One channel mapping is applied to both the old and the new pin state
  logic curA, curB, oldA, oldB;
  always_comb begin
    curA = revQ ? chanB      : chanA;
    curB = revQ ? chanA      : chanB;
    oldA = revQ ? pinPrev[0] : pinPrev[1];
    oldB = revQ ? pinPrev[1] : pinPrev[0];
  end

  logic [1:0] phaseDelta;
  logic       quadUp, quadDn;
  logic       freqEdge, freqUp, freqDn;

  always_comb begin
    phaseDelta = phaseIdx(curA, curB) - phaseIdx(oldA, oldB);
    quadUp     = (phaseDelta == 2'd1);
    quadDn     = (phaseDelta == 2'd3);
    freqEdge   = chanA ^ pinPrev[1];
    freqUp     = freqEdge & ~chanB;
    freqDn     = freqEdge &  chanB;
  end

  always_comb begin
    if (modeQ) begin
      steps.stepUp = freqUp;
      steps.stepDn = freqDn;
    end else begin
      steps.stepUp = quadUp;
      steps.stepDn = quadDn;
    end
  end

endmodule

// File: rtl/enc_pos_dp.sv
module enc_pos_dp
  import enc_pos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  step_t            steps,
  output logic [CNT_W-1:0] posCount,
  output logic             countStrobe,
  output logic             dirUp
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      posCount    <= '0;
      countStrobe <= 1'b0;
      dirUp       <= 1'b1;
    end else begin
      countStrobe <= steps.stepUp | steps.stepDn;
      if (steps.stepUp) begin
        posCount <= posCount + ONE;
        dirUp    <= 1'b1;
      end else if (steps.stepDn) begin
        posCount <= posCount - ONE;
        dirUp    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
  import enc_pos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chanA,
  input  logic             chanB,
  input  logic             revSel,
  input  logic             fdMode,
  output logic [CNT_W-1:0] posCount,
  output logic             countStrobe,
  output logic             dirUp
);

  step_t steps;

  enc_pos_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .chanA  (chanA),
    .chanB  (chanB),
    .revSel (revSel),
    .fdMode (fdMode),
    .steps  (steps)
  );

  enc_pos_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .steps       (steps),
    .posCount    (posCount),
    .countStrobe (countStrobe),
    .dirUp       (dirUp)
  );

endmodule

// File: rtl/enc_pos_checker.sv
module enc_pos_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chanA,
  input logic             chanB,
  input logic [CNT_W-1:0] posCount,
  input logic             countStrobe,
  input logic             dirUp
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rstSeen) begin
      reset_state_chk: assert (posCount == '0 && !countStrobe && dirUp);
    end
  end

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !countStrobe |-> posCount == $past(posCount));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (countStrobe && dirUp) |-> (posCount - $past(posCount)) == ONE);

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (countStrobe && !dirUp) |-> ($past(posCount) - posCount) == ONE);

  // R5
  quiet_pins_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(chanA) && $stable(chanB)) |=> !countStrobe);

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !countStrobe |-> dirUp == $past(dirUp));

endmodule

bind enc_pos_counter enc_pos_checker #(.CNT_W(CNT_W)) chk (
  .clk         (clk),
  .rst         (rst),
  .chanA       (chanA),
  .chanB       (chanB),
  .posCount    (posCount),
  .countStrobe (countStrobe),
  .dirUp       (dirUp)
);

// File: tb/enc_pos_counter_test.sv
`timescale 1ns/1ps
module enc_pos_counter_test;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic         chanA, chanB, revSel, fdMode;
  logic [W-1:0] posCount;
  logic         countStrobe, dirUp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  enc_pos_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .chanA(chanA), .chanB(chanB),
    .revSel(revSel), .fdMode(fdMode),
    .posCount(posCount), .countStrobe(countStrobe), .dirUp(dirUp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // position in the forward cycle 00,10,11,01 of a state (a,b)
  function automatic int ordOf(input bit a, input bit b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int expDelta(input bit md, input bit rv, input bit [1:0] p, input bit [1:0] n);
    int d;
    if (md) begin
      if (p[1] == n[1]) return 0;
      return n[0] ? -1 : 1;
    end
    if (rv) d = (ordOf(n[0], n[1]) - ordOf(p[0], p[1]) + 4) % 4;
    else    d = (ordOf(n[1], n[0]) - ordOf(p[1], p[0]) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  // Apply one pin move at a falling edge and check the result one edge later
  task automatic stepCheck(input bit [1:0] n, input int delta, input string req);
    logic [W-1:0] base, expC;
    logic         dirBefore;
    bit           expDir;
    base = posCount;
    dirBefore = dirUp;
    {chanA, chanB} = n;
    @(negedge clk);
    expC   = base + W'(delta);
    expDir = (delta > 0) ? 1'b1 : (delta < 0) ? 1'b0 : dirBefore;
    check(posCount == expC, req, int'(posCount), int'(expC));
    check(countStrobe == (delta != 0), {req, " R8 strobe"}, int'(countStrobe), int'(delta != 0));
    check(dirUp == expDir, {req, " R4 dir"}, int'(dirUp), int'(expDir));
    @(negedge clk);
    check(countStrobe == 1'b0, "R8 one-cycle strobe", int'(countStrobe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] snap;
    bit sawStrobe;
    rst = 1'b1; chanA = 1'b0; chanB = 1'b0; revSel = 1'b0; fdMode = 1'b0;
    idle(4);
    check(posCount == '0 && !countStrobe && dirUp, "R1 in reset", int'(posCount), 0);
    rst = 1'b0;
    @(negedge clk);
    check(posCount == '0 && !countStrobe && dirUp, "R1 after release", int'(posCount), 0);

    // Exhaustive pair sweep over mode x reverse x previous x next state
    for (int md = 0; md < 2; md++) begin
      for (int rv = 0; rv < 2; rv++) begin
        for (int p = 0; p < 4; p++) begin
          for (int n = 0; n < 4; n++) begin
            int dl;
            string req;
            fdMode = md[0]; revSel = rv[0];
            {chanA, chanB} = p[1:0];
            idle(3);
            dl = expDelta(md[0], rv[0], p[1:0], n[1:0]);
            if (md != 0)      req = "R7 freq/dir";
            else if (rv != 0) req = "R6 swapped";
            else if (dl > 0)  req = "R2 up";
            else if (dl < 0)  req = "R3 down";
            else              req = "R5 no count";
            stepCheck(n[1:0], dl, req);
          end
        end
      end
    end

    // R10: settings toggled with steady pins never step
    chanA = 1'b1; chanB = 1'b1; idle(3);
    snap = posCount; sawStrobe = 0;
    for (int i = 0; i < 8; i++) begin
      revSel = i[0]; fdMode = i[1];
      @(negedge clk);
      if (countStrobe) sawStrobe = 1;
    end
    idle(2);
    check(posCount == snap && !sawStrobe, "R10 static pins", int'(posCount), int'(snap));

    // R10: reverse change lands with a pin move; old setting decodes it
    fdMode = 1'b0; revSel = 1'b0; {chanA, chanB} = 2'b00; idle(3);
    revSel = 1'b1;
    stepCheck(2'b10, 1, "R10 same-edge rev old=0");
    stepCheck(2'b11, -1, "R10 next step rev new=1");
    revSel = 1'b0;
    stepCheck(2'b01, -1, "R10 same-edge rev old=1");
    // mode change lands with an A edge: still quadrature for that step
    {chanA, chanB} = 2'b00; idle(3);
    fdMode = 1'b1;
    stepCheck(2'b11, 0, "R10 same-edge mode old=quad");
    stepCheck(2'b01, -1, "R10 next step mode new=freq");
    fdMode = 1'b0;

    // R9: wrap both ways from a fresh reset
    rst = 1'b1; {chanA, chanB} = 2'b00; idle(3); rst = 1'b0; idle(2);
    stepCheck(2'b01, -1, "R9 wrap below zero");
    check(posCount == {W{1'b1}}, "R9 all ones", int'(posCount), (1 << W) - 1);
    stepCheck(2'b00, 1, "R9 wrap to zero");
    for (int i = 0; i < (1 << W); i++) begin
      bit [1:0] seq [4] = '{2'b10, 2'b11, 2'b01, 2'b00};
      {chanA, chanB} = seq[i % 4];
      @(negedge clk);
    end
    idle(2);
    check(posCount == '0, "R9 full turn returns to zero", int'(posCount), 0);
    check(dirUp == 1'b1, "R4 dir after up run", int'(dirUp), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule